// File: doc/BRIEF.md
# Guest Instruction Step Controller

This block carries out the bookkeeping half of stepping one guest instruction on behalf of a host processor. The host hands over a 32-bit guest instruction word together with a step variant code. The block sorts the instruction into one of four classes and computes the effective address of a load or store operand. It decides whether the step is allowed, and updates the guest program counter and a cycle-budget counter it owns. The arithmetic, the memory access itself and branch target resolution belong to other logic.

A normal step is refused when an interrupt is pending or the cycle budget has run out. A second variant always goes through, so that instructions sitting in a branch delay slot can never be split from their branch. A third variant behaves like the normal one but leaves the PC where it is. The host may also write the PC and the budget directly. The base register of a memory operand is read through a combinational register-file port: the block presents the index and the register file returns the value in the same cycle. Results are registered and appear one cycle after the strobe, with a one-cycle done pulse.

Top module: `gstep_ctrl`

## Requirements
- R1: After reset, step_done, step_ok, step_cls and step_addr are 0, guest_pc equals the PC_RESET parameter (default 0) and cycle_budget is 0.
- R2: A step_valid strobe with step_sel equal to 0x00C (normal), 0x04C (ignore interrupts) or 0x08C (hold PC) gives step_done high for exactly the following cycle. Any other step_sel value gives no done pulse and leaves guest_pc and cycle_budget unchanged.
- R3: On a successful step, step_cls is 4'b0001 for a branch or jump, 4'b0010 for a store, 4'b0100 for a load, 4'b1000 for arithmetic/logical and 4'b0000 for anything else, and it is never more than one-hot. The major opcode is bits 31:26 and the function field is bits 5:0. Major opcodes 0x02–0x07 count as branches, as does opcode 0x01 when bits 20:16 are 0x00, 0x01, 0x10 or 0x11, and opcode 0x00 with function 0x08 or 0x09. Opcodes 0x08–0x0F are arithmetic, as is opcode 0x00 with function 0x00–0x07, 0x10–0x13, 0x18–0x1B or 0x20–0x2B. Opcodes 0x20–0x26 are loads and 0x28–0x2E are stores. Coprocessor moves (0x10, 0x12) and everything else count as other.
- R4: A normal or hold-PC step fails when irq_pending is high or cycle_budget is 0. In that case step_ok is 0, step_cls and step_addr are 0, and guest_pc and cycle_budget keep their values.
- R5: A successful normal step sets step_ok, adds 4 to guest_pc and subtracts 1 from cycle_budget.
- R6: An ignore-interrupts step always succeeds, whatever irq_pending and cycle_budget hold. It advances guest_pc by 4 and decrements cycle_budget, but a budget of 0 stays at 0.
- R7: A successful hold-PC step leaves guest_pc unchanged and decrements cycle_budget.
- R8: base_idx shows instruction bits 25:21. A successful load or store returns base_data plus the sign-extended bits 15:0 in step_addr. Every other step returns 0 there.
- R9: pc_load and budget_load write guest_pc and cycle_budget at the next edge and win over a step update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Step request strobe |
| step_sel | input | 11 | Step variant code |
| instr | input | 32 | Guest instruction word |
| irq_pending | input | 1 | Guest interrupt pending |
| base_idx | output | 5 | Register-file read index (instr bits 25:21) |
| base_data | input | XLEN | Register-file read data for base_idx |
| pc_load | input | 1 | Write guest PC |
| pc_load_val | input | XLEN | New guest PC value |
| budget_load | input | 1 | Write cycle budget |
| budget_load_val | input | CNT_W | New cycle budget value |
| step_done | output | 1 | Result valid pulse |
| step_ok | output | 1 | Step succeeded |
| step_cls | output | 4 | One-hot instruction class |
| step_addr | output | XLEN | Effective memory address or 0 |
| guest_pc | output | XLEN | Guest program counter |
| cycle_budget | output | CNT_W | Remaining cycle budget |

## Verification
Several rules are checked on every cycle: the done pulse follows a legal strobe, the class stays one-hot or zero, and a failed step returns a zero class and address. An ignore-interrupts step always succeeds, a normal step with an interrupt pending fails, a hold-PC step keeps the PC, and an empty budget never wraps. Only the directed scenarios can show the actual values. These are the class returned for each opcode group and the sign-extended address sums. They also cover the exact PC and budget values after each variant, refusal on an empty budget, and the priority of host writes over a step in the same cycle.

// File: rtl/gstep_pkg.sv
// gstep_pkg: shared constants and types for the guest step controller.
// Assumes a 32-bit guest instruction word with the major opcode in the top six bits.
package gstep_pkg;

    localparam int INSTR_W = 32;
    localparam int SEL_W   = 11;
    localparam int CLS_W   = 4;
    localparam int IDX_W   = 5;

    localparam logic [SEL_W-1:0] SEL_NORM = 11'h00C;
    localparam logic [SEL_W-1:0] SEL_IGN  = 11'h04C;
    localparam logic [SEL_W-1:0] SEL_HOLD = 11'h08C;

    localparam logic [CLS_W-1:0] CLS_NONE = 4'b0000;
    localparam logic [CLS_W-1:0] CLS_BR   = 4'b0001;
    localparam logic [CLS_W-1:0] CLS_ST   = 4'b0010;
    localparam logic [CLS_W-1:0] CLS_LD   = 4'b0100;
    localparam logic [CLS_W-1:0] CLS_ALU  = 4'b1000;

    typedef enum logic [1:0] {
        VAR_NONE,
        VAR_NORM,
        VAR_IGN,
        VAR_HOLD
    } variant_e;

    // Map a variant code onto the internal variant type.
    function automatic variant_e decode_sel(input logic [SEL_W-1:0] sel);
        variant_e v;
        case (sel)
            SEL_NORM: v = VAR_NORM;
            SEL_IGN:  v = VAR_IGN;
            SEL_HOLD: v = VAR_HOLD;
            default:  v = VAR_NONE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gstep_classify.sv
// gstep_classify: combinational sort of a guest instruction into a one-hot class.
// Assumes the standard field layout: opcode 31:26, rt 20:16, funct 5:0.
// Also flags whether the instruction carries a memory operand.
module gstep_classify
    import gstep_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [CLS_W-1:0]   cls,
    output logic               is_mem
);

    logic [5:0] op;
    logic [5:0] funct;
    logic [4:0] rt;
    logic       regimm_br;
    logic       special_br;
    logic       special_alu;

    assign op    = instr[31:26];
    assign rt    = instr[20:16];
    assign funct = instr[5:0];

    // Which register-immediate sub-codes are real branches.
    always_comb begin
        regimm_br = (rt == 5'h00) || (rt == 5'h01) || (rt == 5'h10) || (rt == 5'h11);
    end

    // Sort the register-register function codes into jumps and ALU operations.
    always_comb begin
        special_br  = (funct == 6'h08) || (funct == 6'h09);
        special_alu = (funct <= 6'h07)
                   || ((funct >= 6'h10) && (funct <= 6'h13))
                   || ((funct >= 6'h18) && (funct <= 6'h1B))
                   || ((funct >= 6'h20) && (funct <= 6'h2B));
    end

    // Top-level class selection by major opcode.
    always_comb begin
        cls    = CLS_NONE;
        is_mem = 1'b0;
        if (op == 6'h00) begin
            if (special_br)       cls = CLS_BR;
            else if (special_alu) cls = CLS_ALU;
        end else if (op == 6'h01) begin
            if (regimm_br) cls = CLS_BR;
        end else if (op <= 6'h07) begin
            cls = CLS_BR;
        end else if (op <= 6'h0F) begin
            cls = CLS_ALU;
        end else if ((op >= 6'h20) && (op <= 6'h26)) begin
            cls    = CLS_LD;
            is_mem = 1'b1;
        end else if ((op >= 6'h28) && (op <= 6'h2E)) begin
            cls    = CLS_ST;
            is_mem = 1'b1;
        end
    end

endmodule

// File: rtl/gstep_gate.sv
// gstep_gate: decides whether a step request is legal and whether it may proceed.
// Assumes budget_zero reflects the budget register before this cycle's update.
module gstep_gate
    import gstep_pkg::*;
(
    input  logic             step_valid,
    input  logic [SEL_W-1:0] step_sel,
    input  logic             irq_pending,
    input  logic             budget_zero,
    output logic             fire,
    output logic             ok,
    output logic             adv_pc,
    output logic             dec_budget
);

    variant_e var_q;

    assign var_q = decode_sel(step_sel);

    // Accept, allow and derive the state updates for this request.
    always_comb begin
        fire       = step_valid && (var_q != VAR_NONE);
        ok         = fire && ((var_q == VAR_IGN) || (!irq_pending && !budget_zero));
        adv_pc     = ok && (var_q != VAR_HOLD);
        dec_budget = ok && !budget_zero;
    end

endmodule

// File: rtl/gstep_state.sv
// gstep_state: holds the guest PC and the cycle budget.
// Host writes take priority over step updates. The budget saturates at zero.
module gstep_state #(
    parameter int                XLEN     = 32,
    parameter int                CNT_W    = 16,
    parameter logic [XLEN-1:0]   PC_RESET = '0,
    parameter int                PC_STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_pc,
    input  logic             dec_budget,
    input  logic             pc_load,
    input  logic [XLEN-1:0]  pc_load_val,
    input  logic             budget_load,
    input  logic [CNT_W-1:0] budget_load_val,
    output logic [XLEN-1:0]  pc,
    output logic [CNT_W-1:0] budget,
    output logic             budget_zero
);

    localparam logic [XLEN-1:0]  PC_INC  = XLEN'(PC_STEP);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Guest program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= PC_RESET;
        else if (pc_load) pc <= pc_load_val;
        else if (adv_pc)  pc <= pc + PC_INC;
    end

    // Cycle budget register with saturation at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                         budget <= '0;
        else if (budget_load)               budget <= budget_load_val;
        else if (dec_budget && !budget_zero) budget <= budget - CNT_ONE;
    end

    assign budget_zero = (budget == '0);

endmodule

// File: rtl/gstep_ctrl.sv
// gstep_ctrl: top of the guest instruction step controller.
// Sorts the instruction, gates the step, updates PC and budget, and registers
// class, address and success flag one cycle after the strobe.
// Assumes base_data returns the register selected by base_idx in the same cycle.
module gstep_ctrl
    import gstep_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CNT_W    = 16,
    parameter logic [XLEN-1:0] PC_RESET = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_valid,
    input  logic [SEL_W-1:0]     step_sel,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 irq_pending,
    output logic [IDX_W-1:0]     base_idx,
    input  logic [XLEN-1:0]      base_data,
    input  logic                 pc_load,
    input  logic [XLEN-1:0]      pc_load_val,
    input  logic                 budget_load,
    input  logic [CNT_W-1:0]     budget_load_val,
    output logic                 step_done,
    output logic                 step_ok,
    output logic [CLS_W-1:0]     step_cls,
    output logic [XLEN-1:0]      step_addr,
    output logic [XLEN-1:0]      guest_pc,
    output logic [CNT_W-1:0]     cycle_budget
);

    localparam int IMM_W = 16;
    localparam int EXT_W = XLEN - IMM_W;

    logic [CLS_W-1:0] cls_c;
    logic             is_mem;
    logic             fire;
    logic             ok_c;
    logic             adv_pc;
    logic             dec_budget;
    logic             budget_zero;
    logic [XLEN-1:0]  ea_c;

    assign base_idx = instr[25:21];

    gstep_classify u_classify (
        .instr  (instr),
        .cls    (cls_c),
        .is_mem (is_mem)
    );

    gstep_gate u_gate (
        .step_valid  (step_valid),
        .step_sel    (step_sel),
        .irq_pending (irq_pending),
        .budget_zero (budget_zero),
        .fire        (fire),
        .ok          (ok_c),
        .adv_pc      (adv_pc),
        .dec_budget  (dec_budget)
    );

    gstep_state #(
        .XLEN     (XLEN),
        .CNT_W    (CNT_W),
        .PC_RESET (PC_RESET),
        .PC_STEP  (4)
    ) u_state (
        .clk             (clk),
        .rst_n           (rst_n),
        .adv_pc          (adv_pc),
        .dec_budget      (dec_budget),
        .pc_load         (pc_load),
        .pc_load_val     (pc_load_val),
        .budget_load     (budget_load),
        .budget_load_val (budget_load_val),
        .pc              (guest_pc),
        .budget          (cycle_budget),
        .budget_zero     (budget_zero)
    );

    // Effective address: base plus sign-extended displacement.
    always_comb begin
        ea_c = base_data + {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    end

    // Register the step result; failed or idle cycles present zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_done <= 1'b0;
            step_ok   <= 1'b0;
            step_cls  <= CLS_NONE;
            step_addr <= '0;
        end else begin
            step_done <= fire;
            step_ok   <= ok_c;
            step_cls  <= ok_c ? cls_c : CLS_NONE;
            step_addr <= (ok_c && is_mem) ? ea_c : '0;
        end
    end

endmodule

// File: rtl/gstep_ctrl_chk.sv
// gstep_ctrl_chk: cycle-level properties of the step controller, bound to the top.
module gstep_ctrl_chk
    import gstep_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_valid,
    input logic [SEL_W-1:0]   step_sel,
    input logic               irq_pending,
    input logic               pc_load,
    input logic               budget_load,
    input logic               step_done,
    input logic               step_ok,
    input logic [CLS_W-1:0]   step_cls,
    input logic [XLEN-1:0]    step_addr,
    input logic [XLEN-1:0]    guest_pc,
    input logic [CNT_W-1:0]   cycle_budget
);

    logic legal;
    assign legal = (step_sel == SEL_NORM) || (step_sel == SEL_IGN) || (step_sel == SEL_HOLD);

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && legal) |=> step_done); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_valid && legal) |=> !step_done); // R2
    AST_CLS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_cls)); // R3
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && !step_ok) |-> (step_cls == '0 && step_addr == '0)); // R4
    AST_NORM_IRQ_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_sel == SEL_NORM && irq_pending) |=> !step_ok); // R4
    AST_IGN_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_sel == SEL_IGN) |=> (step_ok && step_done)); // R6
    AST_BUDGET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_budget == '0 && !budget_load) |=> cycle_budget == '0); // R6
    AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_sel == SEL_HOLD && !pc_load) |=> $stable(guest_pc)); // R7

endmodule

bind gstep_ctrl gstep_ctrl_chk #(
    .XLEN  (XLEN),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_valid   (step_valid),
    .step_sel     (step_sel),
    .irq_pending  (irq_pending),
    .pc_load      (pc_load),
    .budget_load  (budget_load),
    .step_done    (step_done),
    .step_ok      (step_ok),
    .step_cls     (step_cls),
    .step_addr    (step_addr),
    .guest_pc     (guest_pc),
    .cycle_budget (cycle_budget)
);

// File: tb/gstep_ctrl_bench.sv
// Directed bench for gstep_ctrl: one task per scenario, each checking its own results.
module gstep_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int CNT_W = 16;

    localparam logic [10:0] V_NORM = 11'h00C;
    localparam logic [10:0] V_IGN  = 11'h04C;
    localparam logic [10:0] V_HOLD = 11'h08C;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_valid = 1'b0;
    logic [10:0]      step_sel = '0;
    logic [31:0]      instr = '0;
    logic             irq_pending = 1'b0;
    logic [4:0]       base_idx;
    logic [XLEN-1:0]  base_data;
    logic             pc_load = 1'b0;
    logic [XLEN-1:0]  pc_load_val = '0;
    logic             budget_load = 1'b0;
    logic [CNT_W-1:0] budget_load_val = '0;
    logic             step_done;
    logic             step_ok;
    logic [3:0]       step_cls;
    logic [XLEN-1:0]  step_addr;
    logic [XLEN-1:0]  guest_pc;
    logic [CNT_W-1:0] cycle_budget;

    logic [XLEN-1:0]  rf [32];
    int               total = 0;
    int               bad = 0;
    logic             finished = 1'b0;
    logic [XLEN-1:0]  exp_pc = '0;
    logic [CNT_W-1:0] exp_bud = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign base_data = rf[base_idx];

    gstep_ctrl #(.XLEN(XLEN), .CNT_W(CNT_W)) u_gstep_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .step_valid      (step_valid),
        .step_sel        (step_sel),
        .instr           (instr),
        .irq_pending     (irq_pending),
        .base_idx        (base_idx),
        .base_data       (base_data),
        .pc_load         (pc_load),
        .pc_load_val     (pc_load_val),
        .budget_load     (budget_load),
        .budget_load_val (budget_load_val),
        .step_done       (step_done),
        .step_ok         (step_ok),
        .step_cls        (step_cls),
        .step_addr       (step_addr),
        .guest_pc        (guest_pc),
        .cycle_budget    (cycle_budget)
    );

    // Count one check; report a mismatch.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Host write of PC and/or budget, then verify both registers.
    task automatic host_load(input logic do_pc, input logic [XLEN-1:0] pcv,
                             input logic do_bud, input logic [CNT_W-1:0] budv);
        @(negedge clk);
        pc_load = do_pc; pc_load_val = pcv;
        budget_load = do_bud; budget_load_val = budv;
        @(negedge clk);
        pc_load = 1'b0; budget_load = 1'b0;
        if (do_pc) exp_pc = pcv;
        if (do_bud) exp_bud = budv;
        chk("R9 pc after load", 64'(guest_pc), 64'(exp_pc));
        chk("R9 budget after load", 64'(cycle_budget), 64'(exp_bud));
    endtask

    // One step request; expected state is derived from the variant and expected outcome.
    task automatic do_step(input string tag, input logic [10:0] sel, input logic [31:0] iw,
                           input logic irq, input logic e_ok, input logic [3:0] e_cls,
                           input logic [XLEN-1:0] e_addr);
        @(negedge clk);
        step_valid = 1'b1; step_sel = sel; instr = iw; irq_pending = irq;
        @(negedge clk);
        step_valid = 1'b0; irq_pending = 1'b0;
        if (e_ok) begin
            if (sel != V_HOLD) exp_pc = exp_pc + 32'd4;
            if (exp_bud != '0) exp_bud = exp_bud - 1'b1;
        end
        chk({tag, " R2 done"}, 64'(step_done), 64'(1));
        chk({tag, " ok"}, 64'(step_ok), 64'(e_ok));
        chk({tag, " R3 cls"}, 64'(step_cls), 64'(e_cls));
        chk({tag, " R8 addr"}, 64'(step_addr), 64'(e_addr));
        chk({tag, " pc"}, 64'(guest_pc), 64'(exp_pc));
        chk({tag, " budget"}, 64'(cycle_budget), 64'(exp_bud));
    endtask

    // R1: values straight after reset.
    task automatic t_reset();
        chk("R1 done", 64'(step_done), 64'(0));
        chk("R1 ok", 64'(step_ok), 64'(0));
        chk("R1 cls", 64'(step_cls), 64'(0));
        chk("R1 addr", 64'(step_addr), 64'(0));
        chk("R1 pc", 64'(guest_pc), 64'(0));
        chk("R1 budget", 64'(cycle_budget), 64'(0));
    endtask

    // R5: successful normal step.
    task automatic t_normal();
        host_load(1'b1, 32'h100, 1'b1, 16'd3);
        do_step("R5 addiu", V_NORM, {6'h09, 5'd1, 5'd2, 16'h0005}, 1'b0, 1'b1, 4'b1000, '0);
        chk("R5 pc value", 64'(guest_pc), 64'(32'h104));
        chk("R5 budget value", 64'(cycle_budget), 64'(2));
        @(negedge clk);
        chk("R2 done drops", 64'(step_done), 64'(0));
    endtask

    // R3/R8: class codes and addresses over opcode groups.
    task automatic t_classes();
        host_load(1'b0, '0, 1'b1, 16'd100);
        do_step("R3 beq", V_NORM, {6'h04, 5'd1, 5'd2, 16'h0010}, 1'b0, 1'b1, 4'b0001, '0);
        do_step("R3 j", V_NORM, {6'h02, 26'h0000040}, 1'b0, 1'b1, 4'b0001, '0);
        do_step("R3 jr", V_NORM, {6'h00, 5'd31, 15'd0, 6'h08}, 1'b0, 1'b1, 4'b0001, '0);
        do_step("R3 bgez", V_NORM, {6'h01, 5'd3, 5'h01, 16'h0004}, 1'b0, 1'b1, 4'b0001, '0);
        do_step("R3 regimm other", V_NORM, {6'h01, 5'd3, 5'h05, 16'h0004}, 1'b0, 1'b1, 4'b0000, '0);
        do_step("R3 add", V_NORM, {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 1'b0, 1'b1, 4'b1000, '0);
        do_step("R3 ori", V_NORM, {6'h0D, 5'd1, 5'd2, 16'h00FF}, 1'b0, 1'b1, 4'b1000, '0);
        do_step("R3 mtc0", V_NORM, {6'h10, 5'h04, 5'd2, 5'd12, 11'd0}, 1'b0, 1'b1, 4'b0000, '0);
        do_step("R3 cop2", V_NORM, {6'h12, 5'h00, 5'd2, 5'd9, 11'd0}, 1'b0, 1'b1, 4'b0000, '0);
        do_step("R3 syscall", V_NORM, {6'h00, 20'd0, 6'h0C}, 1'b0, 1'b1, 4'b0000, '0);
        do_step("R8 lw negdisp", V_NORM, {6'h23, 5'd5, 5'd2, 16'hFFFC}, 1'b0, 1'b1, 4'b0100, 32'h0FFF_FFFC);
        do_step("R8 sb posdisp", V_NORM, {6'h28, 5'd6, 5'd2, 16'h0008}, 1'b0, 1'b1, 4'b0010, 32'h0000_0018);
    endtask

    // R4: refusal on pending interrupt and on empty budget.
    task automatic t_fail();
        do_step("R4 irq lw", V_NORM, {6'h23, 5'd5, 5'd2, 16'h0004}, 1'b1, 1'b0, 4'b0000, '0);
        host_load(1'b0, '0, 1'b1, 16'd0);
        do_step("R4 empty budget", V_NORM, {6'h09, 5'd1, 5'd2, 16'h0001}, 1'b0, 1'b0, 4'b0000, '0);
        do_step("R4 hold empty", V_HOLD, {6'h09, 5'd1, 5'd2, 16'h0001}, 1'b0, 1'b0, 4'b0000, '0);
    endtask

    // R6: ignore-interrupts variant, including saturation at zero.
    task automatic t_ignore();
        do_step("R6 ign zero budget", V_IGN, {6'h2B, 5'd6, 5'd2, 16'h0000}, 1'b1, 1'b1, 4'b0010, 32'h10);
        chk("R6 budget stays 0", 64'(cycle_budget), 64'(0));
        host_load(1'b0, '0, 1'b1, 16'd2);
        do_step("R6 ign dec", V_IGN, {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21}, 1'b1, 1'b1, 4'b1000, '0);
        chk("R6 budget is 1", 64'(cycle_budget), 64'(1));
    endtask

    // R7: hold-PC variant success and refusal.
    task automatic t_hold();
        host_load(1'b1, 32'h300, 1'b1, 16'd5);
        do_step("R7 hold ok", V_HOLD, {6'h04, 5'd1, 5'd2, 16'h0001}, 1'b0, 1'b1, 4'b0001, '0);
        chk("R7 pc held", 64'(guest_pc), 64'(32'h300));
        chk("R7 budget 4", 64'(cycle_budget), 64'(4));
        do_step("R7 hold irq", V_HOLD, {6'h04, 5'd1, 5'd2, 16'h0001}, 1'b1, 1'b0, 4'b0000, '0);
    endtask

    // R2: unknown variant code is ignored.
    task automatic t_bad_sel();
        @(negedge clk);
        step_valid = 1'b1; step_sel = 11'h10C; instr = {6'h09, 26'd1};
        @(negedge clk);
        step_valid = 1'b0;
        chk("R2 bad sel no done", 64'(step_done), 64'(0));
        chk("R2 bad sel pc", 64'(guest_pc), 64'(exp_pc));
        chk("R2 bad sel budget", 64'(cycle_budget), 64'(exp_bud));
    endtask

    // R9: host writes win over a simultaneous step.
    task automatic t_load_prio();
        @(negedge clk);
        step_valid = 1'b1; step_sel = V_NORM; instr = {6'h09, 26'd1};
        pc_load = 1'b1; pc_load_val = 32'h200;
        budget_load = 1'b1; budget_load_val = 16'd7;
        @(negedge clk);
        step_valid = 1'b0; pc_load = 1'b0; budget_load = 1'b0;
        exp_pc = 32'h200; exp_bud = 16'd7;
        chk("R9 prio pc", 64'(guest_pc), 64'(32'h200));
        chk("R9 prio budget", 64'(cycle_budget), 64'(7));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'h0;
        rf[5] = 32'h1000_0000;
        rf[6] = 32'h0000_0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_classes();
        t_fail();
        t_ignore();
        t_hold();
        t_bad_sel();
        t_load_prio();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule